// File: doc/BRIEF.md
# Extended Match Timer Bank with Selectable Tick Rates

The block holds eight extended match channels, numbered 4 to 11. Each channel has a 32-bit counter, a 32-bit match value and a control word. The control word picks the rate that advances the channel's counter from five tick strobes. It also chooses whether the channel compares against its own counter or against a counter shared within its group, and whether a match clears that counter. A further bit decides whether the channel fires once or keeps firing on every later match.

A match sets the channel's bit in a status word. The single interrupt output is high while any status bit is set. Software clears status bits by writing ones to them. Channels 9 and 11 can be set up so that a read of their counter also copies the counter of channel 8 or channel 10 into a snapshot register. Software can then read both values as if taken at the same instant.

The prescalers that produce the tick rates are outside the block. Each rate arrives as a single-cycle strobe on `rate_tick`.

Top module: `xmatch_timer`

## Requirements
- R1: After reset, every counter, match value, control word, status bit and the snapshot read 0, and `irq` is low.
- R2: Control bits [2:0] select the strobe that advances the counter: 1 selects `rate_tick[0]` (32.768 kHz), 2 selects `rate_tick[1]` (1 kHz), 3 selects `rate_tick[2]` (1 Hz), 4 selects `rate_tick[3]` (1 MHz) and 5 selects `rate_tick[4]` (external). The counter advances by exactly one per selected strobe. Codes 0, 6 and 7 stop the counter, and a stopped counter keeps its value and still reads back.
- R3: When control bit 7 is set, a channel uses its own counter. When bit 7 is clear, channels 4 to 7 use counter 4, channels 8 and 9 use counter 8, and channels 10 and 11 use counter 10. The counter of a channel that has bit 7 clear and is not 4, 8 or 10 never advances.
- R4: For channels 8 to 11, control bit 8 set stops that channel's counter, whatever the value of bits [2:0].
- R5: A control write keeps bits [7:0] for channels 4 to 7 and bits [9:0] for channels 8 to 11. The other bits read as 0.
- R6: A match occurs when a strobe moves the channel's selected counter onto the channel's match value. The match sets status bit N for channel N, in the clock edge of that strobe.
- R7: When control bit 3 is set, the strobe that would move the selected counter onto the match value loads 0 into that counter instead.
- R8: When control bit 6 is clear, a channel matches at most once. A write to its match register or its control word re-arms it. When bit 6 is set, the channel matches on every later occurrence.
- R9: `irq` is high exactly while any status bit 4 to 11 is set. Writing a 1 to a status bit at offset 0x14 clears it, unless a match sets it in the same cycle.
- R10: When control bit 9 of channel 9 (or 11) is set, a read of that channel's counter copies counter 8 (or 10) into the snapshot register at offset 0x20. When bit 9 is clear, the read leaves the snapshot unchanged.
- R11: The register map has counter N at 0x40+4(N-4), match N at 0x80+4(N-4) and control N at 0xC0+4(N-4). A write to a counter loads that value, and the write takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers a snapshot) |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| rate_tick | input | 5 | Rate strobes: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| irq | output | 1 | Combined interrupt of all extended channels |

## Verification
On every cycle, the assertions check the following. Counters hold when there is no strobe and no write. A status bit can rise only after a strobe. The interrupt falls only after a status write. The snapshot changes only after a read. A channel with bit 8 set does not count. The bench scenarios are needed for the rest. They show which strobe each rate code selects and that a non-owner sharer stays stopped. They also show how a match behaves when it is one-shot, periodic or clears the counter, the register masks, and the snapshot values themselves.

// File: rtl/xmatch_timer.sv
module xmatch_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [4:0]    rate_tick,
  output logic          irq
);
  localparam int NCH = 8;
  localparam logic [7:0] A_STAT = 8'h14;
  localparam logic [7:0] A_SNAP = 8'h20;

  logic [NCH-1:0][CW-1:0] cnt, mval;
  logic [NCH-1:0][9:0]    ctrl;
  logic [NCH-1:0]         armed, hit, run, zap;
  logic [NCH-1:0]         stat;
  logic [CW-1:0]          snap;
  logic [7:0]             tsel;

  function automatic int owner(input int i);
    return (i < 4) ? 0 : ((i < 6) ? 4 : 6);
  endfunction

  function automatic int src(input int i, input logic self);
    return self ? i : owner(i);
  endfunction

  wire       aligned = (addr[1:0] == 2'b00);
  wire [2:0] idx     = addr[4:2];
  wire       cnt_sel = aligned && addr[7:5] == 3'b010;
  wire       mat_sel = aligned && addr[7:5] == 3'b100;
  wire       ctl_sel = aligned && addr[7:5] == 3'b110;

  assign tsel = {2'b00, rate_tick, 1'b0};
  assign irq  = |stat;

  always_comb begin
    run = '0;
    hit = '0;
    zap = '0;
    for (int j = 0; j < NCH; j++)
      run[j] = tsel[ctrl[j][2:0]] && (ctrl[j][7] || owner(j) == j)
               && !(j >= 4 && ctrl[j][8]);
    for (int i = 0; i < NCH; i++) begin
      hit[i] = armed[i] && run[src(i, ctrl[i][7])]
               && (cnt[src(i, ctrl[i][7])] + CW'(1) == mval[i]);
      if (hit[i] && ctrl[i][3]) zap[src(i, ctrl[i][7])] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      mval  <= '0;
      ctrl  <= '0;
      armed <= '1;
      stat  <= '0;
      snap  <= '0;
    end else begin
      for (int j = 0; j < NCH; j++) begin
        if (wr_en && cnt_sel && idx == 3'(j))
          cnt[j] <= wdata[CW-1:0];
        else if (run[j])
          cnt[j] <= zap[j] ? '0 : cnt[j] + CW'(1);
        if (wr_en && mat_sel && idx == 3'(j))
          mval[j] <= wdata[CW-1:0];
        if (wr_en && ctl_sel && idx == 3'(j))
          ctrl[j] <= (j < 4) ? {2'b00, wdata[7:0]} : wdata[9:0];
        if (wr_en && (mat_sel || ctl_sel) && idx == 3'(j))
          armed[j] <= 1'b1;
        else if (hit[j] && !ctrl[j][6])
          armed[j] <= 1'b0;
      end
      stat <= (stat & ~((wr_en && addr == A_STAT) ? wdata[11:4] : 8'h00)) | hit;
      if (rd_en && addr == 8'h54 && ctrl[5][9]) snap <= cnt[4];
      else if (rd_en && addr == 8'h5C && ctrl[7][9]) snap <= cnt[6];
    end
  end

  always_comb begin
    rdata = '0;
    if (cnt_sel)              rdata[CW-1:0] = cnt[idx];
    else if (mat_sel)         rdata[CW-1:0] = mval[idx];
    else if (ctl_sel)         rdata[9:0]    = ctrl[idx];
    else if (addr == A_STAT)  rdata[11:4]   = stat;
    else if (addr == A_SNAP)  rdata[CW-1:0] = snap;
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rate_tick == 5'b0) |=> $stable(cnt));

  // R6
  status_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~$past(stat))) |-> $past(|rate_tick));

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en && addr == A_STAT));

  // R10
  snap_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap) |-> $past(rd_en));

  // R4
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[4][8] && !wr_en) |=> $stable(cnt[4]));
endmodule

// File: tb/test_xmatch_timer.sv
module test_xmatch_timer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [4:0]  rate_tick = 0;
  logic        irq;
  int          tests = 0, fails = 0;

  xmatch_timer i_xmatch_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rate_tick(rate_tick), .irq(irq));

  always #2.5 clk = ~clk;

  function automatic bit ticks(input int code, input logic [4:0] t);
    return (code >= 1 && code <= 5) ? t[code-1] : 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(input logic [4:0] t, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rate_tick = t;
      @(negedge clk); rate_tick = 0;
    end
  endtask

  initial begin
    #900000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int code, expc;
    logic [4:0] t;
    v = $urandom(17);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h40, v); check("R1 counter", v, 0);
    rd(8'hD0, v); check("R1 control", v, 0);
    rd(8'h14, v); check("R1 status", v, 0);
    rd(8'h20, v); check("R1 snapshot", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 rate select on channel 4, self-clocked, 1 MHz
    wr(8'hC0, 32'h84);
    pulse(5'b01000, 5);
    pulse(5'b10111, 3);
    rd(8'h40, v); check("R2 count", v, 5);
    wr(8'hC0, 32'h86);
    pulse(5'b11111, 4);
    rd(8'h40, v); check("R2 stopped hold", v, 5);

    // R3 sharing: channel 5 with bit 7 clear stays stopped
    wr(8'hC4, 32'h01);
    pulse(5'b00001, 3);
    rd(8'h44, v); check("R3 sharer stopped", v, 0);
    // R11 counter load, R6 match on shared counter
    wr(8'hC0, 32'h04);
    wr(8'h40, 0);
    wr(8'h84, 3);
    pulse(5'b01000, 2);
    check("R6 no early irq", {31'b0, irq}, 0);
    pulse(5'b01000, 1);
    rd(8'h14, v); check("R6 status", v, 32'h20);
    check("R9 irq set", {31'b0, irq}, 1);
    rd(8'h40, v); check("R11 counter", v, 3);
    wr(8'h14, 32'h20);
    check("R9 irq cleared", {31'b0, irq}, 0);

    // R8 one-shot
    wr(8'h40, 0);
    pulse(5'b01000, 3);
    rd(8'h14, v); check("R8 one-shot", v, 0);
    wr(8'hC4, 32'h40);
    wr(8'h40, 0);
    pulse(5'b01000, 3);
    rd(8'h14, v); check("R8 re-armed", v, 32'h20);
    wr(8'h14, 32'hFFF);
    // R7 reset on match, R8 periodic
    wr(8'hC4, 32'h48);
    wr(8'h40, 0);
    pulse(5'b01000, 3);
    rd(8'h14, v); check("R7 status", v, 32'h20);
    rd(8'h40, v); check("R7 counter cleared", v, 0);
    wr(8'h14, 32'h20);
    pulse(5'b01000, 3);
    rd(8'h14, v); check("R8 periodic", v, 32'h20);
    wr(8'h14, 32'h20);

    // R4 bit 8 stops channel 8
    wr(8'hD0, 32'h104);
    pulse(5'b01000, 4);
    rd(8'h50, v); check("R4 gated", v, 0);

    // R10 snapshot
    wr(8'hD0, 32'h05);
    wr(8'h50, 32'h100);
    pulse(5'b10000, 2);
    wr(8'hD4, 32'h200);
    rd(8'h54, v);
    rd(8'h20, v); check("R10 snapshot ch9", v, 32'h102);
    wr(8'h58, 32'h55);
    rd(8'h5C, v);
    rd(8'h20, v); check("R10 no snapshot bit clear", v, 32'h102);
    wr(8'hDC, 32'h200);
    rd(8'h5C, v);
    rd(8'h20, v); check("R10 snapshot ch11", v, 32'h55);

    // R2 random rate codes on self-clocked channel 7
    for (int it = 0; it < 30; it++) begin
      code = $urandom % 8;
      wr(8'hCC, 32'h80 | code);
      wr(8'h4C, 0);
      expc = 0;
      for (int k = 0; k < 12; k++) begin
        t = 5'($urandom % 32);
        pulse(t, 1);
        if (ticks(code, t)) expc++;
      end
      rd(8'h4C, v); check("R2 random rate", v, expc);
    end

    // R5 masks
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'hC0, v); check("R5 mask ch4", v, 32'hFF);
    wr(8'hD0, 32'hFFFF_FFFF);
    rd(8'hD0, v); check("R5 mask ch8", v, 32'h3FF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule